// File: doc/BRIEF.md
# Eight-Line GPIO Port with Polarity Control

This block is a register-mapped controller for eight general-purpose I/O lines. Each line has a direction bit, a polarity bit and a stored output value. Software asserts or deasserts a line through its output register. The polarity bit decides which pad level an asserted line produces. The direction bit decides whether the pad driver is enabled at all.

Pad inputs pass through a two-flop synchronizer. They are read back through an input register, after the polarity bit of each line has been applied. A rising edge of this polarity-adjusted level latches a per-line interrupt status bit. The status bits are cleared by writing ones. A single interrupt output goes high when any latched status bit is also enabled.

The configuration registers (direction, polarity, output) are always cleared by power-on reset. A strap input decides whether the platform reset also clears them. When the strap keeps them, an output line can hold its level through a platform reset. The interrupt status and enable registers are cleared by both resets in every case.

Top module: `gpio8_port`

## Requirements
- R1: After power-on reset, every readable register (addresses 0 to 5) reads 0, `pad_oe` is 0 and `irq` is 0.
- R2: Address 0 holds the direction byte. Bit i set to 1 makes line i an output (`pad_oe[i]`=1); 0 makes it an input (`pad_oe[i]`=0).
- R3: Address 1 holds the polarity byte (1 = invert). Address 2 holds the output byte (1 = asserted). The pad drive is `pad_out[i]` = output bit XOR polarity bit.
- R4: A read of address 2 returns the stored output byte, whatever the level on `pad_in`.
- R5: Address 3 is read-only. It returns `pad_in` after a two-clock synchronizer, XORed with the polarity byte. A pad change is therefore visible after the second rising clock edge, not after the first.
- R6: When `keep_cfg` is 0, a cycle with `plat_rst_n` low clears the direction, polarity and output bytes. When `keep_cfg` is 1, platform reset leaves them unchanged.
- R7: Status bit i (address 4) is set by a 0-to-1 change of the polarity-adjusted input of line i. With polarity 1, this is a falling edge of the pad.
- R8: Writing a 1 to a bit of address 4 clears that status bit, and writing 0 leaves it alone. If a new edge arrives in the same cycle as the clear, the bit stays set.
- R9: `irq` is 1 exactly when some bit is set both in the status byte and in the enable byte (address 5).
- R10: The status and enable bytes are cleared while `plat_rst_n` is low, whatever the value of `keep_cfg`.
- R11: Reads of addresses 6 and 7 return 0. Writes to addresses 3, 6 and 7 change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| plat_rst_n | input | 1 | Platform reset, synchronous, active low |
| keep_cfg | input | 1 | Strap: 1 keeps the configuration through platform reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| pad_in | input | 8 | Pad input levels, asynchronous |
| pad_out | output | 8 | Pad output levels |
| pad_oe | output | 8 | Pad output enables |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with its default parameters: eight lines and two synchronizer stages. With eight lines, every bit of every register sits at a real position. Each byte pattern therefore reaches a distinct pad. The two-stage depth makes it possible to show that a pad change appears after the second edge and not after the first. It also gives a fixed cycle in which an edge and a clear of the same status bit meet.

// File: rtl/gpio8_pkg.sv
package gpio8_pkg;
    localparam int unsigned LINES  = 8;
    localparam int unsigned ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        ADR_DIR = 3'd0,
        ADR_POL = 3'd1,
        ADR_OUT = 3'd2,
        ADR_IN  = 3'd3,
        ADR_STS = 3'd4,
        ADR_EN  = 3'd5
    } gpio_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] st_d, st_q;

    always_comb begin
        st_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            st_d[i] = st_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q[LAST];

    // R5: the output lags the stage before it by exactly one clock
    generate
        if (STAGES > 1) begin : g_chk
            a_r5_stage_delay: assert property (@(posedge clk) disable iff (!rst_n)
                q == $past(st_q[LAST-1]));
        end
    endgenerate
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             cfg_clr,
    input  logic             wr_dir,
    input  logic             wr_pol,
    input  logic             wr_out,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] dir,
    output logic [WIDTH-1:0] pol,
    output logic [WIDTH-1:0] outv
);
    typedef struct packed {
        logic [WIDTH-1:0] dir;
        logic [WIDTH-1:0] pol;
        logic [WIDTH-1:0] outv;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_clr) begin
            cfg_d = '0;
        end else begin
            if (wr_dir) cfg_d.dir  = wdata;
            if (wr_pol) cfg_d.pol  = wdata;
            if (wr_out) cfg_d.outv = wdata;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign dir  = cfg_q.dir;
    assign pol  = cfg_q.pol;
    assign outv = cfg_q.outv;

    // R6: a platform clear empties the configuration
    a_r6_cfg_cleared: assert property (@(posedge clk) disable iff (!por_n)
        $past(cfg_clr) |-> (cfg_q == '0));
    // R6: without clear or write, the configuration holds
    a_r6_cfg_holds: assert property (@(posedge clk) disable iff (!por_n)
        $past(!cfg_clr && !wr_dir && !wr_pol && !wr_out) |-> (cfg_q == $past(cfg_q)));
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             clr,
    input  logic [WIDTH-1:0] lvl,
    input  logic             wr_sts,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] sts,
    output logic [WIDTH-1:0] en,
    output logic             irq
);
    typedef struct packed {
        logic [WIDTH-1:0] sts;
        logic [WIDTH-1:0] en;
        logic [WIDTH-1:0] prev;
    } irq_t;

    irq_t st_d, st_q;
    logic [WIDTH-1:0] rise;

    assign rise = lvl & ~st_q.prev;

    always_comb begin
        st_d      = st_q;
        st_d.prev = lvl;
        if (clr) begin
            st_d.sts = '0;
            st_d.en  = '0;
        end else begin
            if (wr_sts) st_d.sts = st_q.sts & ~wdata;
            st_d.sts = st_d.sts | rise;
            if (wr_en)  st_d.en = wdata;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sts = st_q.sts;
    assign en  = st_q.en;
    assign irq = |(st_q.sts & st_q.en);

    // R7/R8: a detected edge always lands in status, even against a clear
    a_r8_edge_wins: assert property (@(posedge clk) disable iff (!por_n)
        !$past(clr) |-> (($past(rise) & ~st_q.sts) == '0));
    // R10: platform reset empties status and enable
    a_r10_plat_clear: assert property (@(posedge clk) disable iff (!por_n)
        $past(clr) |-> (st_q.sts == '0 && st_q.en == '0));
    // R9: no interrupt without a pending status bit
    a_r9_irq_source: assert property (@(posedge clk) disable iff (!por_n)
        irq |-> (st_q.sts != '0));
endmodule

// File: rtl/gpio8_port.sv
module gpio8_port
    import gpio8_pkg::*;
#(
    parameter int unsigned NUM_PINS    = LINES,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                por_n,
    input  logic                plat_rst_n,
    input  logic                keep_cfg,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_wr,
    input  logic [NUM_PINS-1:0] reg_wdata,
    output logic [NUM_PINS-1:0] reg_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic                irq
);
    logic                plat_clr, cfg_clr;
    logic                wr_dir, wr_pol, wr_out, wr_sts, wr_en;
    logic [NUM_PINS-1:0] dir_q, pol_q, out_q, sts_q, en_q;
    logic [NUM_PINS-1:0] pad_sync, lvl_adj;

    assign plat_clr = ~plat_rst_n;
    assign cfg_clr  = plat_clr & ~keep_cfg;

    assign wr_dir = reg_wr && (reg_addr == ADR_DIR);
    assign wr_pol = reg_wr && (reg_addr == ADR_POL);
    assign wr_out = reg_wr && (reg_addr == ADR_OUT);
    assign wr_sts = reg_wr && (reg_addr == ADR_STS);
    assign wr_en  = reg_wr && (reg_addr == ADR_EN);

    gpio_cfg_regs #(.WIDTH(NUM_PINS)) u_cfg (
        .clk     (clk),
        .por_n   (por_n),
        .cfg_clr (cfg_clr),
        .wr_dir  (wr_dir),
        .wr_pol  (wr_pol),
        .wr_out  (wr_out),
        .wdata   (reg_wdata),
        .dir     (dir_q),
        .pol     (pol_q),
        .outv    (out_q)
    );

    gpio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (por_n),
        .d     (pad_in),
        .q     (pad_sync)
    );

    assign lvl_adj = pad_sync ^ pol_q;

    gpio_irq #(.WIDTH(NUM_PINS)) u_irq (
        .clk    (clk),
        .por_n  (por_n),
        .clr    (plat_clr),
        .lvl    (lvl_adj),
        .wr_sts (wr_sts),
        .wr_en  (wr_en),
        .wdata  (reg_wdata),
        .sts    (sts_q),
        .en     (en_q),
        .irq    (irq)
    );

    assign pad_out = out_q ^ pol_q;
    assign pad_oe  = dir_q;

    always_comb begin
        case (reg_addr)
            ADR_DIR: reg_rdata = dir_q;
            ADR_POL: reg_rdata = pol_q;
            ADR_OUT: reg_rdata = out_q;
            ADR_IN:  reg_rdata = lvl_adj;
            ADR_STS: reg_rdata = sts_q;
            ADR_EN:  reg_rdata = en_q;
            default: reg_rdata = '0;
        endcase
    end

    // R2: a direction write shows on the enables one clock later
    a_r2_oe_follows_write: assert property (@(posedge clk) disable iff (!por_n)
        (wr_dir && !cfg_clr) |=> (pad_oe == $past(reg_wdata)));
    // R3/R4: readback of the output byte and the pad drive differ only by polarity
    a_r3_drive_vs_readback: assert property (@(posedge clk) disable iff (!por_n)
        (reg_addr == ADR_OUT) |-> (reg_rdata == (pad_out ^ pol_q)));
    // R11: unused addresses read zero
    a_r11_hole_reads_zero: assert property (@(posedge clk) disable iff (!por_n)
        (reg_addr > ADR_EN) |-> (reg_rdata == '0));
endmodule

// File: tb/gpio8_port_tb.sv
module gpio8_port_tb;
    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       plat_rst_n = 1'b1;
    logic       keep_cfg = 1'b0;
    logic [2:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [7:0] pad_in = '0;
    logic [7:0] pad_out, pad_oe;
    logic       irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    gpio8_port u_dut (
        .clk(clk), .por_n(por_n), .plat_rst_n(plat_rst_n), .keep_cfg(keep_cfg),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v);
            check("R1 reg after por", v, 8'h00);
        end
        check("R1 pad_oe", pad_oe, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_drive;
        logic [7:0] v;
        wr(3'd0, 8'hA5);
        wr(3'd2, 8'h3C);
        check("R2 pad_oe", pad_oe, 8'hA5);
        check("R3 pad_out no inversion", pad_out, 8'h3C);
        pad_in = 8'hFF;
        idle(3);
        rd(3'd2, v);
        check("R4 output readback", v, 8'h3C);
        wr(3'd1, 8'h0F);
        check("R3 pad_out inverted", pad_out, 8'h33);
        rd(3'd1, v);
        check("R3 polarity readback", v, 8'h0F);
        rd(3'd2, v);
        check("R4 readback ignores polarity", v, 8'h3C);
    endtask

    task automatic t_input;
        logic [7:0] v;
        idle(3);
        @(negedge clk);
        pad_in = 8'h5A;
        @(negedge clk);
        rd(3'd3, v);
        check("R5 input after one edge", v, 8'hF0);
        @(negedge clk);
        rd(3'd3, v);
        check("R5 input after two edges", v, 8'h55);
    endtask

    task automatic t_edge;
        logic [7:0] v;
        wr(3'd1, 8'h01);
        pad_in = 8'h00;
        idle(4);
        wr(3'd4, 8'hFF);
        rd(3'd4, v);
        check("R8 status cleared", v, 8'h00);
        pad_in = 8'h03;
        idle(4);
        rd(3'd4, v);
        check("R7 rising pad, line 1 only", v, 8'h02);
        pad_in = 8'h00;
        idle(4);
        rd(3'd4, v);
        check("R7 falling pad on inverted line 0", v, 8'h03);
        check("R9 irq with enable 0", {7'd0, irq}, 8'h00);
        wr(3'd5, 8'h01);
        check("R9 irq enabled", {7'd0, irq}, 8'h01);
        wr(3'd4, 8'h01);
        rd(3'd4, v);
        check("R8 write one clears", v, 8'h02);
        check("R9 irq after clear", {7'd0, irq}, 8'h00);
        wr(3'd4, 8'h00);
        rd(3'd4, v);
        check("R8 write zero keeps", v, 8'h02);
    endtask

    task automatic t_race;
        logic [7:0] v;
        wr(3'd4, 8'hFF);
        @(negedge clk);
        pad_in = 8'h08;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'd4; reg_wdata = 8'h08;
        @(negedge clk);
        reg_wr = 1'b0;
        rd(3'd4, v);
        check("R8 edge beats clear", v, 8'h08);
    endtask

    task automatic t_strap;
        logic [7:0] v;
        wr(3'd0, 8'hC3);
        wr(3'd2, 8'h81);
        wr(3'd5, 8'hFF);
        keep_cfg = 1'b1;
        @(negedge clk);
        plat_rst_n = 1'b0;
        idle(2);
        rd(3'd4, v);
        check("R10 status in plat reset, kept cfg", v, 8'h00);
        rd(3'd5, v);
        check("R10 enable in plat reset, kept cfg", v, 8'h00);
        plat_rst_n = 1'b1;
        idle(1);
        rd(3'd0, v);
        check("R6 dir kept", v, 8'hC3);
        rd(3'd1, v);
        check("R6 pol kept", v, 8'h01);
        rd(3'd2, v);
        check("R6 out kept", v, 8'h81);
        keep_cfg = 1'b0;
        wr(3'd5, 8'hFF);
        plat_rst_n = 1'b0;
        idle(2);
        rd(3'd5, v);
        check("R10 enable in plat reset", v, 8'h00);
        plat_rst_n = 1'b1;
        idle(1);
        rd(3'd0, v);
        check("R6 dir cleared", v, 8'h00);
        rd(3'd1, v);
        check("R6 pol cleared", v, 8'h00);
        rd(3'd2, v);
        check("R6 out cleared", v, 8'h00);
        check("R6 pad_oe cleared", pad_oe, 8'h00);
    endtask

    task automatic t_holes;
        logic [7:0] v;
        pad_in = 8'h96;
        idle(4);
        wr(3'd3, 8'h00);
        wr(3'd6, 8'hFF);
        wr(3'd7, 8'hFF);
        rd(3'd3, v);
        check("R11 input ignores write", v, 8'h96);
        rd(3'd6, v);
        check("R11 address 6 reads 0", v, 8'h00);
        rd(3'd7, v);
        check("R11 address 7 reads 0", v, 8'h00);
        rd(3'd0, v);
        check("R11 dir untouched", v, 8'h00);
        rd(3'd5, v);
        check("R11 enable untouched", v, 8'h00);
    endtask

    initial begin
        idle(3);
        por_n = 1'b1;
        idle(2);
        t_reset();
        t_drive();
        t_input();
        t_edge();
        t_race();
        t_strap();
        t_holes();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule